// File: doc/BRIEF.md
# Function Level Reset Tracker

This block keeps one reset-pending flag for each of 4 physical and 252 virtual functions of an endpoint. When the host writes the function-level-reset bit of a function, the configuration logic pulses a write strobe with that function's number, and the tracker raises the function's flag. The flag stays up until the user logic reports that it has finished resetting the function. For a physical function, the user logic reports this on a dedicated done bit. For a virtual function, it sends a done pulse together with the function's number.

Every incoming configuration request carries a function number. In the same cycle, the tracker decides whether the request is answered with a configuration-retry status or goes on to normal handling. A request to a function whose flag is up gets retry. While the global configuration-space enable is low, every request gets retry regardless of the flags.

Function numbers share one 8-bit space. Values 0x00 to 0x03 name physical functions 0 to 3. Values 0x04 to 0xFF name virtual functions 0 to 251, so virtual function k has number k+4.

Each function is a two-state machine:
- States: `SLOT_IDLE` (no reset pending) and `SLOT_RESET` (reset pending).
- Transition START: `SLOT_IDLE` to `SLOT_RESET`, taken on a write strobe for that function.
- Transition FINISH: `SLOT_RESET` to `SLOT_IDLE`, taken on a matching done with no write for the same function in that cycle.
- In every other case the state holds.

Top module: `flr_tracker`

## Requirements
- R1: While reset is asserted and after it is released, every bit of `pf_busy` and `vf_busy` is 0.
- R2: A cycle with `flr_wr_valid` high and `flr_wr_fn` = n sets the flag one clock later. For n in 0x00..0x03 the flag is `pf_busy[n]`; for n in 0x04..0xFF it is `vf_busy[n-4]`.
- R3: A set flag stays set on every clock edge at which no matching done arrives.
- R4: `pf_done[i]` high for one cycle clears `pf_busy[i]` one clock later.
- R5: `vf_done` high with `vf_done_fn` = n in 0x04..0xFF clears `vf_busy[n-4]` one clock later.
- R6: A `vf_done` pulse carrying a reserved number 0x00..0x03 changes no flag; in particular, `pf_busy` is unchanged.
- R7: A done for a function whose flag is clear leaves that flag clear.
- R8: If a write strobe and a done for the same function arrive in the same cycle, the function's flag is set after that clock.
- R9: With `req_valid` high and the flag of function `req_fn` set, `req_retry` is 1 and `req_accept` is 0 in the same cycle.
- R10: With `req_valid` high and `cfg_space_en` low, `req_retry` is 1 and `req_accept` is 0, whatever the flags hold.
- R11: With `req_valid` high, `cfg_space_en` high and the target flag clear, `req_accept` is 1 and `req_retry` is 0. With `req_valid` low, both are 0.
- R12: Flags of different functions are independent: a write or done for one function leaves every other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_space_en | input | 1 | Configuration space enable; low forces retry for every request |
| flr_wr_valid | input | 1 | Host wrote the reset bit of function `flr_wr_fn` |
| flr_wr_fn | input | 8 | Function number of the reset write |
| pf_done | input | 4 | Per-physical-function reset-complete strobes |
| vf_done | input | 1 | Virtual-function reset-complete strobe |
| vf_done_fn | input | 8 | Function number with `vf_done` (0x04..0xFF valid) |
| req_valid | input | 1 | A configuration request is present |
| req_fn | input | 8 | Target function number of the request |
| pf_busy | output | 4 | Reset-pending flags of the physical functions |
| vf_busy | output | 252 | Reset-pending flags of the virtual functions |
| req_retry | output | 1 | Answer the current request with retry status |
| req_accept | output | 1 | Current request proceeds to normal handling |

## Verification
The bench builds the tracker with its defaults: 4 physical functions, 252 virtual functions and an 8-bit function number. With these values the whole 8-bit number space is covered, so both ends of the virtual range (0x04 and 0xFF) and the reserved values 0x00..0x03 are reachable from the ports. A random phase draws function numbers from a small set that includes these edges, so collisions happen often. These include a write and a done for the same function in one cycle, and a done for a function with no reset pending.

// File: rtl/flr_trk_pkg.sv
package flr_trk_pkg;

    // Per-function reset tracking state
    typedef enum logic [0:0] {
        SLOT_IDLE  = 1'b0,
        SLOT_RESET = 1'b1
    } slot_state_e;

endpackage

// File: rtl/flr_fn_decode.sv
// Decodes a qualified function number into a one-hot vector covering
// function numbers FIRST .. NUM_FN-1.
module flr_fn_decode #(
    parameter int FN_W   = 8,
    parameter int NUM_FN = 256,
    parameter int FIRST  = 0,
    localparam int OUT_W = NUM_FN - FIRST
) (
    input  logic              valid_i,
    input  logic [FN_W-1:0]   fn_i,
    output logic [OUT_W-1:0]  hot_o
);

    for (genvar j = 0; j < OUT_W; j++) begin : g_hit
        localparam logic [FN_W-1:0] CODE = FN_W'(FIRST + j);
        assign hot_o[j] = valid_i && (fn_i == CODE);
    end

endmodule

// File: rtl/flr_slot.sv
// Two-state tracker for one function.
module flr_slot
    import flr_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic finish_i,
    output logic busy_o
);

    slot_state_e st_q, st_d;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_IDLE: begin
                if (start_i) st_d = SLOT_RESET;          // START
            end
            SLOT_RESET: begin
                if (finish_i && !start_i) st_d = SLOT_IDLE; // FINISH, write wins
            end
            default: st_d = SLOT_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLOT_IDLE;
        else        st_q <= st_d;
    end

    // Outputs
    always_comb begin
        busy_o = (st_q == SLOT_RESET);
    end

endmodule

// File: rtl/flr_req_gate.sv
// Same-cycle retry/accept decision for a configuration request.
module flr_req_gate #(
    parameter int FN_W   = 8,
    parameter int NUM_FN = 256
) (
    input  logic              req_valid_i,
    input  logic [FN_W-1:0]   req_fn_i,
    input  logic              cfg_en_i,
    input  logic [NUM_FN-1:0] busy_i,
    output logic              retry_o,
    output logic              accept_o
);

    logic [NUM_FN-1:0] hit;
    logic              target_busy;

    for (genvar i = 0; i < NUM_FN; i++) begin : g_sel
        localparam logic [FN_W-1:0] CODE = FN_W'(i);
        assign hit[i] = busy_i[i] && (req_fn_i == CODE);
    end

    always_comb begin
        target_busy = |hit;
        retry_o     = req_valid_i && (!cfg_en_i || target_busy);
        accept_o    = req_valid_i && cfg_en_i && !target_busy;
    end

endmodule

// File: rtl/flr_tracker.sv
module flr_tracker #(
    parameter int NUM_PF = 4,
    parameter int NUM_VF = 252,
    parameter int FN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_space_en,
    input  logic              flr_wr_valid,
    input  logic [FN_W-1:0]   flr_wr_fn,
    input  logic [NUM_PF-1:0] pf_done,
    input  logic              vf_done,
    input  logic [FN_W-1:0]   vf_done_fn,
    input  logic              req_valid,
    input  logic [FN_W-1:0]   req_fn,
    output logic [NUM_PF-1:0] pf_busy,
    output logic [NUM_VF-1:0] vf_busy,
    output logic              req_retry,
    output logic              req_accept
);

    localparam int NUM_FN = NUM_PF + NUM_VF;

    logic [NUM_FN-1:0] wr_hot;
    logic [NUM_VF-1:0] vd_hot;
    logic [NUM_FN-1:0] busy_all;

    flr_fn_decode #(.FN_W(FN_W), .NUM_FN(NUM_FN), .FIRST(0)) u_wr_dec (
        .valid_i (flr_wr_valid),
        .fn_i    (flr_wr_fn),
        .hot_o   (wr_hot)
    );

    // Reserved numbers below NUM_PF decode to nothing
    flr_fn_decode #(.FN_W(FN_W), .NUM_FN(NUM_FN), .FIRST(NUM_PF)) u_vd_dec (
        .valid_i (vf_done),
        .fn_i    (vf_done_fn),
        .hot_o   (vd_hot)
    );

    for (genvar i = 0; i < NUM_FN; i++) begin : g_slot
        logic fin;
        if (i < NUM_PF) begin : g_pf
            assign fin = pf_done[i];
        end else begin : g_vf
            assign fin = vd_hot[i-NUM_PF];
        end
        flr_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (wr_hot[i]),
            .finish_i (fin),
            .busy_o   (busy_all[i])
        );
    end

    assign pf_busy = busy_all[NUM_PF-1:0];
    assign vf_busy = busy_all[NUM_FN-1:NUM_PF];

    flr_req_gate #(.FN_W(FN_W), .NUM_FN(NUM_FN)) u_gate (
        .req_valid_i (req_valid),
        .req_fn_i    (req_fn),
        .cfg_en_i    (cfg_space_en),
        .busy_i      (busy_all),
        .retry_o     (req_retry),
        .accept_o    (req_accept)
    );

endmodule

// File: rtl/flr_tracker_chk.sv
module flr_tracker_chk #(
    parameter int NUM_PF = 4,
    parameter int NUM_VF = 252,
    parameter int FN_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_space_en,
    input logic              flr_wr_valid,
    input logic [FN_W-1:0]   flr_wr_fn,
    input logic [NUM_PF-1:0] pf_done,
    input logic              vf_done,
    input logic [FN_W-1:0]   vf_done_fn,
    input logic              req_valid,
    input logic [FN_W-1:0]   req_fn,
    input logic [NUM_PF-1:0] pf_busy,
    input logic [NUM_VF-1:0] vf_busy,
    input logic              req_retry,
    input logic              req_accept
);

    localparam int NUM_FN = NUM_PF + NUM_VF;

    logic [NUM_FN-1:0] flags;
    logic [FN_W-1:0]   wr_fn_q;
    logic              wr_in_range_q;
    logic              tgt_busy;

    assign flags    = {vf_busy, pf_busy};
    assign tgt_busy = (int'(req_fn) < NUM_FN) && flags[req_fn];

    always_ff @(posedge clk) begin
        wr_fn_q       <= flr_wr_fn;
        wr_in_range_q <= rst_n && flr_wr_valid && (int'(flr_wr_fn) < NUM_FN);
    end

    AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_in_range_q |-> flags[wr_fn_q]); // R2

    AST_RETRY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && tgt_busy) |-> (req_retry && !req_accept)); // R9

    AST_RETRY_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_space_en) |-> (req_retry && !req_accept)); // R10

    AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_space_en && !tgt_busy) |-> (req_accept && !req_retry)); // R11

    AST_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!req_retry && !req_accept)); // R11

    AST_PF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_done == '0 && !flr_wr_valid) |=> $stable(pf_busy)); // R6

    for (genvar i = 0; i < NUM_PF; i++) begin : g_pf_chk
        localparam logic [FN_W-1:0] CODE = FN_W'(i);
        AST_PF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (pf_busy[i] && !pf_done[i]) |=> pf_busy[i]); // R3
        AST_PF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (pf_done[i] && !(flr_wr_valid && flr_wr_fn == CODE)) |=> !pf_busy[i]); // R4
    end

endmodule

bind flr_tracker flr_tracker_chk #(
    .NUM_PF(NUM_PF), .NUM_VF(NUM_VF), .FN_W(FN_W)
) u_chk (.*);

// File: tb/flr_tracker_bench.sv
`timescale 1ns/1ps
module flr_tracker_bench;

    localparam int NPF = 4;
    localparam int NVF = 252;
    localparam int NFN = NPF + NVF;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cfg_space_en;
    logic           flr_wr_valid;
    logic [7:0]     flr_wr_fn;
    logic [NPF-1:0] pf_done;
    logic           vf_done;
    logic [7:0]     vf_done_fn;
    logic           req_valid;
    logic [7:0]     req_fn;
    logic [NPF-1:0] pf_busy;
    logic [NVF-1:0] vf_busy;
    logic           req_retry;
    logic           req_accept;

    int checks   = 0;
    int failures = 0;
    bit model [NFN];

    always #4 clk = ~clk; // 125 MHz

    flr_tracker u_flr_tracker (
        .clk, .rst_n, .cfg_space_en, .flr_wr_valid, .flr_wr_fn, .pf_done,
        .vf_done, .vf_done_fn, .req_valid, .req_fn, .pf_busy, .vf_busy,
        .req_retry, .req_accept
    );

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [NPF-1:0] epf;
        logic [NVF-1:0] evf;
        logic           eretry, eaccept, tb;
        for (int i = 0; i < NPF; i++) epf[i] = model[i];
        for (int i = 0; i < NVF; i++) evf[i] = model[i+NPF];
        tb      = model[req_fn];
        eretry  = req_valid && (!cfg_space_en || tb);
        eaccept = req_valid && cfg_space_en && !tb;
        check({tag, " pf flags"}, 256'(pf_busy), 256'(epf));
        check({tag, " vf flags"}, 256'(vf_busy), 256'(evf));
        check({tag, " retry/accept"}, 256'({req_retry, req_accept}), 256'({eretry, eaccept}));
    endtask

    // Drive one cycle from a negedge, compare, then update the model at the edge
    task automatic step(input string tag, input bit wr, input logic [7:0] wfn,
                        input logic [3:0] pd, input bit vd, input logic [7:0] vfn,
                        input bit rv, input logic [7:0] rfn, input bit en);
        flr_wr_valid = wr; flr_wr_fn = wfn; pf_done = pd; vf_done = vd;
        vf_done_fn = vfn; req_valid = rv; req_fn = rfn; cfg_space_en = en;
        #1;
        compare(tag);
        @(posedge clk);
        for (int i = 0; i < NFN; i++) begin
            bit fin;
            fin = (i < NPF) ? pd[i] : (vd && int'(vfn) == i);
            if (wr && int'(wfn) == i) model[i] = 1'b1;
            else if (fin)             model[i] = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input bit rv, input logic [7:0] rfn);
        step(tag, 0, 8'h00, 4'h0, 0, 8'h00, rv, rfn, 1);
    endtask

    function automatic logic [7:0] pick_fn(input int r);
        case (r % 8)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h02; 3: return 8'h03;
            4: return 8'h04; 5: return 8'h05; 6: return 8'hFE; default: return 8'hFF;
        endcase
    endfunction

    initial begin
        #(8ns * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_space_en = 1'b1; flr_wr_valid = 0; flr_wr_fn = 0;
        pf_done = 0; vf_done = 0; vf_done_fn = 0; req_valid = 0; req_fn = 0;
        for (int i = 0; i < NFN; i++) model[i] = 1'b0;
        // Writes during reset must not stick (R1)
        @(negedge clk); flr_wr_valid = 1; flr_wr_fn = 8'h02;
        repeat (3) @(negedge clk);
        flr_wr_valid = 0;
        #1; check("R1 in reset", 256'({vf_busy, pf_busy}), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 256'({vf_busy, pf_busy}), 256'(0));

        step("R2 pf write",  1, 8'h02, 4'h0, 0, 8'h00, 0, 8'h00, 1);
        idle("R9 busy pf retry",  1, 8'h02);
        idle("R11 idle pf accept", 1, 8'h01);
        step("R2 vf low write",  1, 8'h04, 4'h0, 0, 8'h00, 1, 8'h02, 1);
        step("R2 vf high write", 1, 8'hFF, 4'h0, 0, 8'h00, 1, 8'h04, 1);
        idle("R9 busy vf retry",   1, 8'hFF);
        repeat (4) idle("R3 hold", 1, 8'h04);
        step("R6 reserved done", 0, 8'h00, 4'h0, 1, 8'h02, 1, 8'h02, 1);
        idle("R6 pf still set", 1, 8'h02);
        step("R4 pf done", 0, 8'h00, 4'h4, 0, 8'h00, 1, 8'h02, 1);
        idle("R4 pf cleared", 1, 8'h02);
        step("R5 vf done", 0, 8'h00, 4'h0, 1, 8'h04, 1, 8'h04, 1);
        idle("R5 vf cleared", 1, 8'h04);
        step("R7 stray vf done", 0, 8'h00, 4'h0, 1, 8'h04, 0, 8'h00, 1);
        step("R7 stray pf done", 0, 8'h00, 4'h8, 0, 8'h00, 1, 8'h03, 1);
        idle("R7 still clear", 1, 8'h03);
        step("R8 vf collide", 1, 8'h10, 4'h0, 1, 8'h10, 0, 8'h00, 1);
        idle("R8 vf set", 1, 8'h10);
        step("R8 pf collide", 1, 8'h01, 4'h2, 0, 8'h00, 0, 8'h00, 1);
        idle("R8 pf set", 1, 8'h01);
        step("R12 done other", 0, 8'h00, 4'h0, 1, 8'hFF, 1, 8'h10, 1);
        idle("R12 others kept", 1, 8'hFF);
        idle("R10 disabled", 0, 8'h00);
        step("R10 disabled idle fn", 0, 8'h00, 4'h0, 0, 8'h00, 1, 8'h30, 0);
        step("R10 disabled busy fn", 0, 8'h00, 4'h0, 0, 8'h00, 1, 8'h10, 0);
        idle("R11 no request", 0, 8'h10);

        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom;
            step("R12 random", (r & 3) == 0, pick_fn(r >> 2), 4'((r >> 5) & ((r & 32'h1000) != 0 ? 15 : 0)),
                 ((r >> 9) & 3) == 0, pick_fn(r >> 11), ((r >> 14) & 1) == 1,
                 pick_fn(r >> 15), ((r >> 18) & 7) != 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule